// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three byte-wide general-purpose ports, called A, B and C, behind a small register interface. The processor reaches them through an active-low select, active-low read and write strobes, a two-bit register address and a byte-wide data bus. A write to the control address does one of two things. It either defines the direction and mode of every port, or it sets or clears one chosen line of port C. Port C is split into two 4-bit halves, and each half has its own direction.

In the plain mode, output values are held in latches that keep driving the pads after the access ends. Input reads return whatever is on the pins in that cycle. Port B can also run in a strobed mode. There, three low lines of port C become a strobe/acknowledge input, a buffer-status output and an interrupt-request output. Port B can then take in bytes captured by an external strobe, or hand bytes out under an acknowledge handshake. Pads are shown as separate in, out and output-enable vectors. All accesses are sampled on the rising clock edge in any cycle where the select and a strobe are both low.

Top module: `ppi_top`

## Requirements
- R1: The address selects the register: 2'b00 port A, 2'b01 port B, 2'b10 port C, 2'b11 control. After reset every port is an input in plain mode with all latches at 0, and a control read returns 8'h9B.
- R2: While cs_n is high, a low wr_n changes no latch and a low rd_n does not raise bus_oe.
- R3: A control write with bit 7 set is a mode word. Bit 4 is the port A direction, bit 3 the direction of port C bits 7..4, bit 2 the port B mode (1 = strobed), bit 1 the port B direction and bit 0 the direction of port C bits 3..0. A direction of 1 means input, so the pad output-enables of that port (or nibble) are low. A control read returns the last mode word.
- R4: Every mode word clears the A, B and C output latches to 0 and clears the port B handshake state.
- R5: A value written to an output port stays on its pad outputs until the next write, and a read of that port returns the latch.
- R6: A read of a plain-mode input returns the pin values present in the read cycle, with nothing latched.
- R7: The two halves of port C follow their own direction bits independently, for output enables and for read data.
- R8: A control write with bit 7 clear sets (bit 0 = 1) or clears (bit 0 = 0) the port C latch bit numbered by bits 3..1. It leaves the other latch bits and the mode word unchanged.
- R9: Bits 6..5 of the mode word are stored and read back but do not change port A, which always acts in plain mode.
- R10: With port B strobed, port C bit 2 is an input and bits 1 and 0 are driven outputs, whatever the lower-nibble direction is; bit 3 still follows that direction. A port C read returns the interrupt request in bit 0, the buffer flag in bit 1 and the interrupt enable (port C latch bit 2) in bit 2.
- R11: Strobed input: a high-to-low change on port C bit 2 captures port B's pins and sets port C bit 1 (buffer full) high. A read of port B returns the captured byte and clears buffer full.
- R12: Strobed input: port C bit 0 (interrupt request) rises after the strobe returns high, but only if the interrupt enable is 1 and the buffer is full. A read of port B clears it.
- R13: Strobed output: a port B write drives port C bit 1 low (output buffer full, active low) and clears the interrupt request. A low on port C bit 2 (acknowledge) returns bit 1 high. The acknowledge's return high raises the interrupt request when the enable is 1.
- R14: Read data and bus_oe appear one clock after the edge that samples the read strobe and stay for one cycle per sampled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Block select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| bus_in | input | 8 | Write data from the processor |
| bus_out | output | 8 | Registered read data |
| bus_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pad inputs |
| pa_out | output | 8 | Port A pad outputs |
| pa_oe | output | 8 | Port A pad output enables |
| pb_in | input | 8 | Port B pad inputs |
| pb_out | output | 8 | Port B pad outputs |
| pb_oe | output | 8 | Port B pad output enables |
| pc_in | input | 8 | Port C pad inputs |
| pc_out | output | 8 | Port C pad outputs |
| pc_oe | output | 8 | Port C pad output enables |

## Verification
The bench steps through all 64 mode words made of the four direction bits and the two stored port A mode bits. For each one it checks the enables, the readback and the latch clearing, so a swapped or inverted direction bit shows up as a wrong enable or wrong read source in one nibble. Each iteration writes, drives and reads back different byte patterns, which separates latch data from pin data. Bit set/reset is swept over all eight lines in both polarities, so an index off by one lands on the wrong pad. The strobed mode is run in both directions with the interrupt enable on and off, and the pins are changed after capture, which shows whether data is held or passed straight through.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } ppi_sel_e;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_hs;
    logic       b_in;
    logic       cl_in;
  } ppi_cfg_t;

  localparam ppi_cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                     b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // control word bit positions
  localparam int MW_FLAG   = 7;
  localparam int MW_AM_LO  = 5;
  localparam int MW_A_DIR  = 4;
  localparam int MW_CU_DIR = 3;
  localparam int MW_B_MODE = 2;
  localparam int MW_B_DIR  = 1;
  localparam int MW_CL_DIR = 0;

  // port C lines taken over by the port B handshake
  localparam int HS_INTR = 0;
  localparam int HS_FLAG = 1;
  localparam int HS_STB  = 2;
endpackage

// File: rtl/ppi_regs.sv
module ppi_regs
  import ppi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  ppi_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  output ppi_cfg_t      cfg,
  output logic [DW-1:0] a_lat,
  output logic [DW-1:0] b_lat,
  output logic [DW-1:0] c_lat,
  output logic          mode_wr
);
  localparam int IW = $clog2(DW);

  logic          ctl_wr;
  logic          bsr_wr;
  logic [IW-1:0] bsr_idx;

  assign ctl_wr  = wr_en && (wr_sel == SEL_CTL);
  assign mode_wr = ctl_wr && wr_data[MW_FLAG];
  assign bsr_wr  = ctl_wr && !wr_data[MW_FLAG];
  assign bsr_idx = wr_data[IW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= CFG_RESET;
      a_lat <= '0;
      b_lat <= '0;
      c_lat <= '0;
    end else if (mode_wr) begin
      cfg   <= '{a_mode: wr_data[MW_AM_LO +: 2], a_in: wr_data[MW_A_DIR],
                 cu_in: wr_data[MW_CU_DIR], b_hs: wr_data[MW_B_MODE],
                 b_in: wr_data[MW_B_DIR], cl_in: wr_data[MW_CL_DIR]};
      a_lat <= '0;
      b_lat <= '0;
      c_lat <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_A:   a_lat <= wr_data;
        SEL_B:   b_lat <= wr_data;
        SEL_C:   c_lat <= wr_data;
        default: if (bsr_wr) c_lat[bsr_idx] <= wr_data[0];
      endcase
    end
  end

  assert_mode_clear_R4: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (a_lat == '0 && b_lat == '0 && c_lat == '0));

  assert_bsr_keeps_cfg_R8: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> $stable(cfg));
endmodule

// File: rtl/ppi_hs.sv
module ppi_hs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dir_in,
  input  logic          clr,
  input  logic          stb_n,
  input  logic [DW-1:0] pins,
  input  logic          rd_port,
  input  logic          wr_port,
  input  logic          inte,
  output logic          flag,
  output logic          intr,
  output logic [DW-1:0] cap
);
  logic stb_q;
  logic fall;
  logic rise;

  assign fall = stb_q && !stb_n;
  assign rise = !stb_q && stb_n;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b1;
    else     stb_q <= stb_n;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      flag <= 1'b0;
      intr <= 1'b0;
      cap  <= '0;
    end else if (dir_in) begin
      if (rd_port) begin
        flag <= 1'b0;
        intr <= 1'b0;
      end
      if (fall) begin
        cap  <= pins;
        flag <= 1'b1;
      end
      if (rise && inte && flag) intr <= 1'b1;
    end else begin
      if (wr_port) begin
        flag <= 1'b1;
        intr <= 1'b0;
      end
      if (fall) flag <= 1'b0;
      if (rise && inte && !flag) intr <= 1'b1;
    end
  end

  assert_intr_needs_full_R12: assert property (@(posedge clk) disable iff (rst)
    (en && dir_in && intr) |-> flag);

  assert_strobe_sets_full_R11: assert property (@(posedge clk) disable iff (rst)
    (en && dir_in && !clr && stb_q && !stb_n) |=> flag);

  assert_ack_releases_R13: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_in && !clr && !wr_port && stb_q && !stb_n) |=> !flag);
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int HALF = DW / 2;

  ppi_sel_e      sel;
  logic          acc_wr;
  logic          acc_rd;
  ppi_cfg_t      cfg;
  logic [DW-1:0] a_lat, b_lat, c_lat, b_cap;
  logic          mode_wr;
  logic          hs_flag, hs_intr;
  logic [1:0]    hs_bits;
  logic [DW-1:0] c_rd;
  logic [DW-1:0] rd_mux;

  assign sel    = ppi_sel_e'(addr);
  assign acc_wr = !cs_n && !wr_n;
  assign acc_rd = !cs_n && !rd_n;

  ppi_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(acc_wr), .wr_sel(sel), .wr_data(bus_in),
    .cfg(cfg), .a_lat(a_lat), .b_lat(b_lat), .c_lat(c_lat), .mode_wr(mode_wr)
  );

  ppi_hs #(.DW(DW)) hs_i (
    .clk(clk), .rst(rst), .en(cfg.b_hs), .dir_in(cfg.b_in), .clr(mode_wr),
    .stb_n(pc_in[HS_STB]), .pins(pb_in),
    .rd_port(acc_rd && sel == SEL_B), .wr_port(acc_wr && sel == SEL_B),
    .inte(c_lat[HS_STB]), .flag(hs_flag), .intr(hs_intr), .cap(b_cap)
  );

  // buffer status is active high for input, active low for output
  assign hs_bits = {cfg.b_in ? hs_flag : !hs_flag, hs_intr};

  assign pa_out = a_lat;
  assign pa_oe  = {DW{!cfg.a_in}};
  assign pb_out = b_lat;
  assign pb_oe  = {DW{!cfg.b_in}};

  for (genvar i = 0; i < DW; i++) begin : g_pc
    logic nib_in;
    if (i >= HALF) begin : g_up
      assign nib_in = cfg.cu_in;
    end else begin : g_lo
      assign nib_in = cfg.cl_in;
    end
    if (i == HS_INTR || i == HS_FLAG) begin : g_hs_out
      assign pc_oe[i]  = cfg.b_hs ? 1'b1 : !nib_in;
      assign pc_out[i] = cfg.b_hs ? hs_bits[i] : c_lat[i];
      assign c_rd[i]   = cfg.b_hs ? hs_bits[i] : (nib_in ? pc_in[i] : c_lat[i]);
    end else if (i == HS_STB) begin : g_hs_in
      assign pc_oe[i]  = cfg.b_hs ? 1'b0 : !nib_in;
      assign pc_out[i] = c_lat[i];
      assign c_rd[i]   = cfg.b_hs ? c_lat[i] : (nib_in ? pc_in[i] : c_lat[i]);
    end else begin : g_plain
      assign pc_oe[i]  = !nib_in;
      assign pc_out[i] = c_lat[i];
      assign c_rd[i]   = nib_in ? pc_in[i] : c_lat[i];
    end
  end

  always_comb begin
    case (sel)
      SEL_A:   rd_mux = cfg.a_in ? pa_in : a_lat;
      SEL_B:   rd_mux = cfg.b_in ? (cfg.b_hs ? b_cap : pb_in) : b_lat;
      SEL_C:   rd_mux = c_rd;
      default: rd_mux = DW'({1'b1, cfg});
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else begin
      bus_oe <= acc_rd;
      if (acc_rd) bus_out <= rd_mux;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && !bus_oe));

  assert_read_timing_R14: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(acc_rd));

  assert_hs_lines_R10: assert property (@(posedge clk) disable iff (rst)
    cfg.b_hs |-> (pc_oe[HS_INTR] && pc_oe[HS_FLAG] && !pc_oe[HS_STB]));
endmodule

// File: tb/ppi_top_tb.sv
module ppi_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h04;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ppi_top dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; bus_in = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 chk("R14 no data before edge", bus_oe, 1'b0);
    @(negedge clk);
    chk("R14 data one clock later", bus_oe, 1'b1);
    d = bus_out;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] acc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 reset pa_oe", pa_oe, 8'h00);
    chk("R1 reset pb_oe", pb_oe, 8'h00);
    chk("R1 reset pc_oe", pc_oe, 8'h00);
    chk("R1 reset latches", {pa_out, pb_out, pc_out}, 24'h0);
    bus_read(2'b11, rd);
    chk("R1 reset control", rd, 8'h9B);

    // R3 R4 R5 R6 R7 R9: sweep of all plain-mode words
    for (int m = 0; m < 64; m++) begin
      logic [7:0] word, va, vb, vc, ia, ib, ic, ec;
      logic a_i, cu_i, b_i, cl_i;
      a_i = m[3]; cu_i = m[2]; b_i = m[1]; cl_i = m[0];
      word = {1'b1, m[5:4], a_i, cu_i, 1'b0, b_i, cl_i};
      bus_write(2'b00, 8'hFF);
      bus_write(2'b01, 8'hFF);
      bus_write(2'b10, 8'hFF);
      bus_write(2'b11, word);
      chk("R4 latches cleared", {pa_out, pb_out, pc_out}, 24'h0);
      chk("R3 R9 pa_oe", pa_oe, a_i ? 8'h00 : 8'hFF);
      chk("R3 pb_oe", pb_oe, b_i ? 8'h00 : 8'hFF);
      chk("R7 pc_oe", pc_oe, {cu_i ? 4'h0 : 4'hF, cl_i ? 4'h0 : 4'hF});
      bus_read(2'b11, rd);
      chk("R3 R9 control readback", rd, word);
      va = 8'(m * 29 + 3); vb = 8'(m * 53 + 7); vc = 8'(m * 11 + 90);
      ia = 8'(m * 71 + 5); ib = 8'(~(m * 13)); ic = 8'(m * 97 + 41);
      bus_write(2'b00, va);
      bus_write(2'b01, vb);
      bus_write(2'b10, vc);
      chk("R5 pads hold latches", {pa_out, pb_out, pc_out}, {va, vb, vc});
      pa_in = ia; pb_in = ib; pc_in = ic;
      bus_read(2'b00, rd);
      chk("R5 R6 R9 port A read", rd, a_i ? ia : va);
      bus_read(2'b01, rd);
      chk("R5 R6 port B read", rd, b_i ? ib : vb);
      ec = {cu_i ? ic[7:4] : vc[7:4], cl_i ? ic[3:0] : vc[3:0]};
      bus_read(2'b10, rd);
      chk("R7 port C read", rd, ec);
      pc_in = 8'h04;
    end

    // R6 unlatched input
    bus_write(2'b11, 8'h9B);
    pa_in = 8'h3C;
    bus_read(2'b00, rd);
    chk("R6 live pins first", rd, 8'h3C);
    pa_in = 8'hC5;
    bus_read(2'b00, rd);
    chk("R6 live pins second", rd, 8'hC5);

    // R2 select high blocks access
    bus_write(2'b11, 8'h80);
    bus_write(2'b00, 8'h3C);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; rd_n = 1'b0; addr = 2'b00; bus_in = 8'hC3;
    @(negedge clk);
    chk("R2 write ignored", pa_out, 8'h3C);
    chk("R2 no read drive", bus_oe, 1'b0);
    wr_n = 1'b1; rd_n = 1'b1;

    // R8 bit set/reset sweep
    acc = 8'h00;
    for (int b = 0; b < 8; b++) begin
      bus_write(2'b11, 8'((b << 1) | 1));
      acc[b] = 1'b1;
      chk("R8 set bit", pc_out, acc);
    end
    for (int b = 7; b >= 0; b--) begin
      bus_write(2'b11, 8'(b << 1));
      acc[b] = 1'b0;
      chk("R8 clear bit", pc_out, acc);
    end
    bus_read(2'b11, rd);
    chk("R8 mode word kept", rd, 8'h80);

    // R10 pin takeover
    pc_in = 8'h04;
    bus_write(2'b11, 8'h87);
    chk("R10 oe lower input", pc_oe, 8'hF3);
    bus_write(2'b11, 8'h86);
    chk("R10 oe lower output", pc_oe, 8'hFB);

    // R11 R12 strobed input with enable off and on
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      logic en_i;
      v = 8'(k * 67 + 19);
      en_i = k[0];
      bus_write(2'b11, en_i ? 8'h05 : 8'h04);
      chk("R11 empty before strobe", pc_out[1:0], 2'b00);
      pb_in = v;
      @(negedge clk) pc_in[2] = 1'b0;
      @(negedge clk);
      chk("R11 full after strobe", pc_out[1], 1'b1);
      chk("R12 no request while low", pc_out[0], 1'b0);
      pb_in = ~v; pc_in[2] = 1'b1;
      @(negedge clk);
      chk("R12 request after strobe rise", pc_out[0], en_i);
      bus_read(2'b10, rd);
      chk("R10 port C status read", rd[2:0], {en_i, 1'b1, en_i});
      bus_read(2'b01, rd);
      chk("R11 captured byte", rd, v);
      chk("R11 R12 cleared by read", pc_out[1:0], 2'b00);
    end

    // R4 mode word clears handshake
    @(negedge clk) pc_in[2] = 1'b0;
    @(negedge clk) pc_in[2] = 1'b1;
    chk("R11 full again", pc_out[1], 1'b1);
    bus_write(2'b11, 8'h86);
    chk("R4 handshake cleared", pc_out[1:0], 2'b00);

    // R13 strobed output
    for (int k = 0; k < 2; k++) begin
      logic [7:0] v;
      v = 8'(k * 111 + 33);
      bus_write(2'b11, 8'h84);
      chk("R13 obf idle high", pc_out[1], 1'b1);
      bus_write(2'b11, k[0] ? 8'h05 : 8'h04);
      bus_write(2'b01, v);
      chk("R13 port B drives", {pb_oe, pb_out}, {8'hFF, v});
      chk("R13 obf low after write", pc_out[1:0], 2'b00);
      @(negedge clk) pc_in[2] = 1'b0;
      @(negedge clk);
      chk("R13 ack releases obf", pc_out[1], 1'b1);
      pc_in[2] = 1'b1;
      @(negedge clk);
      chk("R13 request after ack", pc_out[0], k[0]);
      bus_write(2'b01, ~v);
      chk("R13 write clears request", pc_out[1:0], 2'b00);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule